// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, frame by frame, whether a received Ethernet frame should be kept. It watches the destination address bytes as they arrive in wire order and compares them with the station's own address. It also detects the all-ones broadcast address and notes the group bit. A multicast hash verdict is computed elsewhere and arrives as a single input. About one cycle after the last address byte, it reports a single accept or reject verdict.

Four control inputs shape the verdict. The first accepts every frame whatever its address. The second stops frames from being kept just because they match the station address. The third rejects the broadcast address. The fourth is the receive enable. The enable is sampled only when a frame begins, so a frame already in progress is never cut short when it is cleared. A frame that begins while receive is disabled produces no verdict. Instead, the block raises a one-cycle missed-frame pulse that an outside counter can total.

Top module: `rxf_addr_filter`

## Requirements
- R1: While reset is held and in the cycle after it is released, `dec_vld`, `dec_accept` and `missed_pulse` are 0.
- R2: `dec_vld` is a one-cycle pulse in the cycle after the clock edge that takes the sixth address byte. It is the only cycle in which `dec_accept` may be 1. A frame that ends before six bytes gives no verdict, and bytes after the sixth give no further verdict.
- R3: A frame whose address equals `station_addr` is accepted while `cfg_no_phys` is 0. While `cfg_no_phys` is 1, that match alone does not accept it.
- R4: The address 48'hFFFF_FFFF_FFFF is accepted while `cfg_no_bcast` is 0 and rejected while it is 1, unless `cfg_promisc` is 1.
- R5: An address whose first byte has bit 0 set, other than broadcast, is accepted exactly when `hash_hit` is 1 in the cycle of the sixth byte. `hash_hit` has no effect on addresses whose first byte has bit 0 clear.
- R6: With `cfg_promisc` at 1 in the cycle of the sixth byte, the verdict is accept for any address.
- R7: An individual address that differs from `station_addr` is rejected when `cfg_promisc` is 0.
- R8: A frame that starts while `cfg_rx_en` is 0 produces a `missed_pulse` in the cycle after `rx_sof`. It produces no verdict, even if `cfg_rx_en` is set before its sixth byte.
- R9: Clearing `cfg_rx_en` after a frame has started does not stop that frame's verdict.
- R10: Address byte i in arrival order (i = 0 first) is compared with `station_addr[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sof | input | 1 | Frame start strobe, carries no byte |
| rx_eof | input | 1 | Frame end strobe, carries no byte |
| rx_vld | input | 1 | `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte, wire order |
| station_addr | input | 48 | Station address, first wire byte in bits 7:0 |
| hash_hit | input | 1 | Multicast hash verdict from outside |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_no_phys | input | 1 | Do not accept on a station-address match |
| cfg_no_bcast | input | 1 | Reject broadcast frames |
| cfg_rx_en | input | 1 | Receive enable, sampled at frame start |
| dec_vld | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Verdict: 1 accept, 0 reject |
| missed_pulse | output | 1 | Frame started while receive was disabled |

## Verification
The bench exercises the two disable controls against broadcast, station, multicast and promiscuous traffic. A design that lets promiscuous lose to a disable, or lets a hash hit rescue a disabled broadcast, would log a wrong verdict. Byte order is probed with a byte-reversed copy of the station address, which a design comparing bytes from the wrong end would accept. The enable is toggled in the middle of a frame in both directions. A design that samples the enable at the sixth byte would drop a verdict after clearing it, or produce a verdict after setting it. Runt frames check that no verdict is issued when the address is incomplete.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic {
      CMP_SERIAL   = 1'b0,
      CMP_PARALLEL = 1'b1
   } cmp_style_e;

   typedef struct packed {
      logic promisc;
      logic no_phys;
      logic no_bcast;
      logic rx_en;
   } rxf_cfg_t;

   typedef struct packed {
      logic phys;
      logic bcast;
      logic group;
   } addr_class_t;

endpackage

// File: rtl/rxf_addr_cmp.sv
module rxf_addr_cmp
   import rxf_pkg::*;
#(
   parameter int         ADDR_BYTES = 6,
   parameter int         BYTE_W     = 8,
   parameter cmp_style_e STYLE      = CMP_SERIAL,
   localparam int        ADDR_W     = ADDR_BYTES * BYTE_W,
   localparam int        CNT_W      = $clog2(ADDR_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [ADDR_W-1:0] station,
   output logic              last_byte,
   output addr_class_t       cls
);

   localparam logic [CNT_W-1:0] IDLE     = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0] cnt;
   logic             taking;

   assign taking    = byte_vld && !frame_start && (cnt < IDLE);
   assign last_byte = taking && (cnt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= IDLE;
      else if (frame_start)  cnt <= '0;
      else if (taking)       cnt <= cnt + CNT_W'(1);
   end

   generate
      if (STYLE == CMP_SERIAL) begin : g_serial
         logic [BYTE_W-1:0] st_b [ADDR_BYTES];
         logic [BYTE_W-1:0] st_cur;
         logic              phys_run, bcast_run, grp_q;

         for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_split
            assign st_b[i] = station[i*BYTE_W +: BYTE_W];
         end

         always_comb begin
            st_cur = '0;
            for (int k = 0; k < ADDR_BYTES; k++)
               if (cnt == CNT_W'(k)) st_cur = st_b[k];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phys_run  <= 1'b0;
               bcast_run <= 1'b0;
               grp_q     <= 1'b0;
            end else if (frame_start) begin
               phys_run  <= 1'b1;
               bcast_run <= 1'b1;
            end else if (taking) begin
               phys_run  <= phys_run  && (byte_in == st_cur);
               bcast_run <= bcast_run && (&byte_in);
               if (cnt == '0) grp_q <= byte_in[0];
            end
         end

         assign cls.phys  = phys_run  && (byte_in == st_cur);
         assign cls.bcast = bcast_run && (&byte_in);
         assign cls.group = (cnt == '0) ? byte_in[0] : grp_q;
      end else begin : g_parallel
         logic [ADDR_W-1:0] sr;
         logic [ADDR_W-1:0] full;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sr <= '0;
            else if (taking) sr <= {byte_in, sr[ADDR_W-1:BYTE_W]};
         end

         assign full      = {byte_in, sr[ADDR_W-1:BYTE_W]};
         assign cls.phys  = (full == station);
         assign cls.bcast = &full;
         assign cls.group = full[0];
      end
   endgenerate

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= IDLE);

   // R2
   one_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_byte |=> !last_byte);

endmodule

// File: rtl/rxf_rx_gate.sv
module rxf_rx_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic frame_end,
   input  logic rx_en,
   output logic frame_active,
   output logic missed_pulse
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_active <= 1'b0;
         missed_pulse <= 1'b0;
      end else if (frame_start) begin
         frame_active <= rx_en;
         missed_pulse <= !rx_en;
      end else begin
         missed_pulse <= 1'b0;
         if (frame_end) frame_active <= 1'b0;
      end
   end

   // R8
   missed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      missed_pulse |-> ($past(frame_start) && !$past(rx_en)));

   // R8
   missed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      missed_pulse |-> !frame_active);

   // R9
   hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_active && !frame_start && !frame_end) |=> frame_active);

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
   import rxf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        last_byte,
   input  logic        frame_active,
   input  addr_class_t cls,
   input  rxf_cfg_t    cfg,
   input  logic        hash_hit,
   output logic        dec_vld,
   output logic        dec_accept
);

   logic take_now, accept_c, mcast_ok;

   assign take_now = last_byte && frame_active;
   assign mcast_ok = cls.group && !cls.bcast && hash_hit;
   assign accept_c = cfg.promisc
                   | (cls.phys  && !cfg.no_phys)
                   | (cls.bcast && !cfg.no_bcast)
                   | mcast_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_vld    <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         dec_vld    <= take_now;
         dec_accept <= take_now && accept_c;
      end
   end

   // R2
   acc_in_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_accept |-> dec_vld);

   // R2
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |=> !dec_vld);

   // R6
   promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && $past(cfg.promisc)) |-> dec_accept);

   // R4
   bcast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && $past(cls.bcast && cfg.no_bcast && !cfg.promisc)) |-> !dec_accept);

   // R8
   gated_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> $past(frame_active));

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
   import rxf_pkg::*;
#(
   parameter int         ADDR_BYTES = 6,
   parameter int         BYTE_W     = 8,
   parameter cmp_style_e STYLE      = CMP_SERIAL,
   localparam int        ADDR_W     = ADDR_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic              rx_vld,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [ADDR_W-1:0] station_addr,
   input  logic              hash_hit,
   input  logic              cfg_promisc,
   input  logic              cfg_no_phys,
   input  logic              cfg_no_bcast,
   input  logic              cfg_rx_en,
   output logic              dec_vld,
   output logic              dec_accept,
   output logic              missed_pulse
);

   initial begin
      assert (ADDR_BYTES >= 2)
         else $error("rxf_addr_filter: ADDR_BYTES must be at least 2");
      assert (BYTE_W >= 1)
         else $error("rxf_addr_filter: BYTE_W must be positive");
   end

   rxf_cfg_t    cfg;
   addr_class_t cls;
   logic        last_byte, frame_active;

   assign cfg = '{promisc: cfg_promisc, no_phys: cfg_no_phys,
                  no_bcast: cfg_no_bcast, rx_en: cfg_rx_en};

   rxf_addr_cmp #(
      .ADDR_BYTES (ADDR_BYTES),
      .BYTE_W     (BYTE_W),
      .STYLE      (STYLE)
   ) u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (rx_sof),
      .byte_vld    (rx_vld),
      .byte_in     (rx_byte),
      .station     (station_addr),
      .last_byte   (last_byte),
      .cls         (cls)
   );

   rxf_rx_gate u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_start  (rx_sof),
      .frame_end    (rx_eof),
      .rx_en        (cfg.rx_en),
      .frame_active (frame_active),
      .missed_pulse (missed_pulse)
   );

   rxf_decide u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .last_byte    (last_byte),
      .frame_active (frame_active),
      .cls          (cls),
      .cfg          (cfg),
      .hash_hit     (hash_hit),
      .dec_vld      (dec_vld),
      .dec_accept   (dec_accept)
   );

   // R1
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!dec_vld && !missed_pulse));

endmodule

// File: tb/tb_rxf_addr_filter.sv
`timescale 1ns/1ps
module tb_rxf_addr_filter;
   localparam int NB = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_sof = 1'b0, rx_eof = 1'b0, rx_vld = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic [47:0] station_addr = 48'h5A_34_12_CD_AB_02;
   logic        hash_hit = 1'b0;
   logic        cfg_promisc = 1'b0, cfg_no_phys = 1'b0, cfg_no_bcast = 1'b0, cfg_rx_en = 1'b0;
   logic        dec_vld, dec_accept, missed_pulse;

   always #4 clk = ~clk;

   rxf_addr_filter dut (
      .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .rx_vld(rx_vld), .rx_byte(rx_byte), .station_addr(station_addr),
      .hash_hit(hash_hit), .cfg_promisc(cfg_promisc), .cfg_no_phys(cfg_no_phys),
      .cfg_no_bcast(cfg_no_bcast), .cfg_rx_en(cfg_rx_en),
      .dec_vld(dec_vld), .dec_accept(dec_accept), .missed_pulse(missed_pulse)
   );

   typedef struct {
      logic  acc;
      int    cyc;
      string req;
   } exp_t;

   exp_t expq[$];
   exp_t mon_e;
   int   checks = 0, fails = 0, cyc = 0;
   int   missed_seen = 0, missed_exp = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   function automatic logic model(input logic [47:0] da, input logic hsh);
      logic bc, ph, grp;
      bc  = &da;
      ph  = (da == station_addr);
      grp = da[0];
      return cfg_promisc | (ph & !cfg_no_phys) | (bc & !cfg_no_bcast) | (grp & !bc & hsh);
   endfunction

   // monitor: pops expected verdicts as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (missed_pulse) missed_seen++;
         if (dec_vld) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R2", "unexpected verdict (accept value)", int'(dec_accept), -1);
            end else begin
               mon_e = expq.pop_front();
               chk(dec_accept === mon_e.acc, mon_e.req, "verdict",
                   int'(dec_accept), int'(mon_e.acc));
               chk(cyc == mon_e.cyc, "R2", "verdict cycle", cyc, mon_e.cyc);
            end
         end
      end
   end

   // driver: one frame; flip_at toggles cfg_rx_en before that byte index
   task automatic send_frame(input logic [47:0] da, input int nbytes,
                             input logic hsh, input string req, input int flip_at);
      logic en_at_sof;
      @(negedge clk);
      rx_sof    = 1'b1;
      hash_hit  = hsh;
      en_at_sof = cfg_rx_en;
      @(negedge clk);
      rx_sof = 1'b0;
      if (!en_at_sof) begin
         missed_exp++;
         // R8: pulse in the cycle after the start strobe
         chk(missed_pulse === 1'b1, "R8", "missed pulse after disabled start",
             int'(missed_pulse), 1);
      end
      for (int i = 0; i < nbytes; i++) begin
         if (i == flip_at) cfg_rx_en = !cfg_rx_en;
         rx_vld  = 1'b1;
         rx_byte = (i < NB) ? da[8*i +: 8] : 8'(i * 37 + 5);
         if (i == NB - 1 && en_at_sof)
            expq.push_back('{acc: model(da, hsh), cyc: cyc + 1, req: req});
         @(negedge clk);
      end
      rx_vld = 1'b0;
      rx_eof = 1'b1;
      @(negedge clk);
      rx_eof = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [47:0] reverse_bytes(input logic [47:0] a);
      logic [47:0] r;
      for (int i = 0; i < NB; i++) r[8*i +: 8] = a[8*(NB-1-i) +: 8];
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(dec_vld === 1'b0 && dec_accept === 1'b0 && missed_pulse === 1'b0, "R1",
          "outputs in reset", int'({dec_vld, dec_accept, missed_pulse}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dec_vld === 1'b0 && missed_pulse === 1'b0, "R1",
          "outputs after reset", int'({dec_vld, missed_pulse}), 0);

      cfg_rx_en = 1'b1;
      // R3 / R10: exact station match, with payload past the address (R2)
      send_frame(station_addr, 10, 1'b0, "R3", -1);
      // R10: byte-reversed station address must not match
      send_frame(reverse_bytes(station_addr), 8, 1'b0, "R10", -1);
      // R3: physical match disabled
      cfg_no_phys = 1'b1;
      send_frame(station_addr, 8, 1'b0, "R3", -1);
      // R3: disabled physical, but group address with hash hit still accepted (R5)
      send_frame(48'h00_00_00_00_5E_01, 8, 1'b1, "R5", -1);
      cfg_no_phys = 1'b0;

      // R4: broadcast
      send_frame('1, 8, 1'b0, "R4", -1);
      cfg_no_bcast = 1'b1;
      send_frame('1, 8, 1'b0, "R4", -1);
      send_frame('1, 8, 1'b1, "R4", -1);
      // R6: promiscuous overrides every disable
      cfg_promisc = 1'b1;
      cfg_no_phys = 1'b1;
      send_frame('1, 8, 1'b0, "R6", -1);
      send_frame(48'h11_22_33_44_55_66, 7, 1'b0, "R6", -1);
      cfg_promisc  = 1'b0;
      cfg_no_phys  = 1'b0;
      cfg_no_bcast = 1'b0;

      // R5: group addresses with and without hash hit
      send_frame(48'h77_00_00_5E_00_01, 8, 1'b1, "R5", -1);
      send_frame(48'h77_00_00_5E_00_01, 8, 1'b0, "R5", -1);
      // R5 / R7: individual non-matching address, hash hit has no effect
      send_frame(48'h77_00_00_5E_00_02, 8, 1'b1, "R7", -1);
      send_frame(station_addr ^ 48'h01_00_00_00_00_00, 8, 1'b0, "R7", -1);

      // R2: runt frame, no verdict
      send_frame(station_addr, 4, 1'b0, "R2", -1);

      // R8: disabled at start, enabled mid-frame: missed pulse, no verdict
      cfg_rx_en = 1'b0;
      send_frame(station_addr, 8, 1'b0, "R8", 2);
      // R9: enabled at start, cleared mid-frame: verdict still produced
      send_frame(station_addr, 8, 1'b0, "R9", 3);
      cfg_rx_en = 1'b1;

      // varied traffic
      for (int k = 0; k < 8; k++) begin
         cfg_no_phys = k[1];
         send_frame((k == 3) ? station_addr
                             : (48'h0F_1E_2D_3C_4B_5A ^ (48'(k) * 48'h01_02_03_04_05_07)),
                    7, k[0], "R5", -1);
      end
      cfg_no_phys = 1'b0;

      repeat (5) @(negedge clk);
      chk(expq.size() == 0, "R2", "verdicts outstanding", expq.size(), 0);
      chk(missed_seen == missed_exp, "R8", "missed pulse count", missed_seen, missed_exp);
      finish_run();
   end
endmodule